// File: doc/BRIEF.md
# PS/2 Keyboard Scancode Receiver

This block listens to the clock and data lines of a PS/2 keyboard and turns the serial frames into one byte per key press. Both lines are sampled with the system clock. The keyboard clock passes through a history filter that rejects short glitches. Each clean falling edge of the filtered clock shifts in one bit of an 11-bit frame: a start bit, eight data bits LSB first, an odd parity bit and a stop bit.

Frames with correct parity go to a key filter. The filter drops the release prefix and the byte that follows it. It also drops the extended-key prefix. Every remaining byte appears on the code output together with a single-cycle valid strobe. The strobe is raised at the stop bit of that key's own frame, so each key is reported once and without lag.

The block runs entirely in the system clock domain and needs no handshake. The consumer only has to watch the strobe.

Top module: `ps2_key_rx`

## Requirements
- R1: While reset is held and just after it, `valid_o` is 0 and `code_o` is 0x00.
- R2: The keyboard clock counts as low only after 8 consecutive low samples and as high only after 8 consecutive high samples. A low pulse shorter than 8 system clocks produces no bit and no start.
- R3: In idle, a filtered falling edge with data 0 starts a frame. The next 8 falling edges carry data bit 0 first through bit 7 last, then comes the parity bit. The falling edge after that is the stop bit, and the received byte is delivered from it.
- R4: `valid_o` is high for exactly one system clock per delivered key.
- R5: `code_o` changes only together with `valid_o` and otherwise holds the last delivered key.
- R6: A frame whose 8 data bits plus parity bit hold an even number of ones is discarded. It gives no strobe and does not alter the prefix state.
- R7: The byte 0xF0 is never delivered. The next byte that is neither 0xF0 nor 0xE0 is also suppressed. A later repeat of that byte is delivered again.
- R8: The byte 0xE0 is never delivered and leaves the release state unchanged. So 0xE0 then X delivers X, and 0xE0, 0xF0, X delivers nothing.
- R9: The strobe for a key comes before the next frame begins: the decision uses the byte just received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Raw keyboard clock line |
| ps2_data_i | input | 1 | Raw keyboard data line |
| code_o | output | 8 | Last delivered key code |
| valid_o | output | 1 | One-cycle strobe for a new code |

## Verification
At the stop edge of a frame, the arrival of a new byte and the clearing of the pending release state happen in the same clock. The bench provokes this by sending 0xF0 and then a key, and then repeating the same key at once. The suppressed byte must produce no strobe, and the repeat must produce exactly one strobe with the right code before the next frame starts. Clock glitches inside an idle gap and inside a bit's high phase are judged by checking that the next byte arrives unshifted.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] BREAK_CODE = 8'hF0;
  localparam logic [DATA_W-1:0] EXT_CODE   = 8'hE0;
  typedef enum logic {ST_IDLE, ST_SHIFT} rx_state_e;
endpackage

// File: rtl/ps2_clk_filter.sv
module ps2_clk_filter #(
  parameter int unsigned FILT_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ps2_clk_i,
  output logic filt_o,
  output logic fall_o
);
  logic [FILT_LEN-1:0] hist_q;
  logic                filt_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '1;
      filt_q <= 1'b1;
      fall_q <= 1'b0;
    end else begin
      hist_q <= {hist_q[FILT_LEN-2:0], ps2_clk_i};
      fall_q <= 1'b0;
      if (&hist_q) begin
        filt_q <= 1'b1;
      end else if (~|hist_q) begin
        filt_q <= 1'b0;
        fall_q <= filt_q;  // high-to-low of the filtered clock
      end
    end
  end

  assign filt_o = filt_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              ps2_data_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_vld_o
);
  localparam int unsigned SH_W  = DATA_W + 1;
  localparam int unsigned CNT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SH_W);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SH_W-1:0]   sreg_q;
  logic [DATA_W-1:0] byte_q;
  logic              vld_q, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sreg_q  <= '0;
      byte_q  <= '0;
      vld_q   <= 1'b0;
      data_q  <= 1'b1;
    end else begin
      data_q <= ps2_data_i;
      vld_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (fall_i && !data_q) state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (fall_i) begin
            if (cnt_q == CNT_LAST) begin  // stop bit
              state_q <= ST_IDLE;
              if (^sreg_q) begin          // odd parity accepted
                byte_q <= sreg_q[DATA_W-1:0];
                vld_q  <= 1'b1;
              end
            end else begin
              sreg_q <= {data_q, sreg_q[SH_W-1:1]};
              cnt_q  <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;
endmodule

// File: rtl/ps2_key_filter.sv
module ps2_key_filter
  import ps2_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              byte_vld_i,
  output logic [DATA_W-1:0] code_o,
  output logic              valid_o,
  output logic              brk_o
);
  logic [DATA_W-1:0] code_q;
  logic              valid_q, brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      valid_q <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (byte_vld_i) begin
        if (byte_i == BREAK_CODE) begin
          brk_q <= 1'b1;
        end else if (byte_i != EXT_CODE) begin
          if (brk_q) begin
            brk_q <= 1'b0;  // released key: swallow
          end else begin
            code_q  <= byte_i;
            valid_q <= 1'b1;
          end
        end
      end
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;
  assign brk_o   = brk_q;
endmodule

// File: rtl/ps2_key_rx.sv
module ps2_key_rx
  import ps2_rx_pkg::*;
#(
  parameter int unsigned FILT_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ps2_clk_i,
  input  logic              ps2_data_i,
  output logic [DATA_W-1:0] code_o,
  output logic              valid_o
);
  logic              filt, fall, frm_vld, brk;
  logic [DATA_W-1:0] frm_byte;

  ps2_clk_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ps2_clk_i(ps2_clk_i),
    .filt_o(filt), .fall_o(fall)
  );

  ps2_frame_rx u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall), .ps2_data_i(ps2_data_i),
    .byte_o(frm_byte), .byte_vld_o(frm_vld)
  );

  ps2_key_filter u_key (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(frm_byte), .byte_vld_i(frm_vld),
    .code_o(code_o), .valid_o(valid_o), .brk_o(brk)
  );
endmodule

// File: rtl/ps2_key_rx_chk.sv
module ps2_key_rx_chk
  import ps2_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fall,
  input logic              frm_vld,
  input logic              brk,
  input logic [DATA_W-1:0] code_o,
  input logic              valid_o
);
  AST_EDGE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> !fall);  // R2
  AST_VALID_FROM_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(frm_vld));  // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);  // R4
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(code_o));  // R5
  AST_NO_BREAK_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (code_o != BREAK_CODE));  // R7
  AST_NOT_AFTER_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !$past(brk));  // R7
  AST_NO_EXT_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (code_o != EXT_CODE));  // R8
endmodule

bind ps2_key_rx ps2_key_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fall(fall), .frm_vld(frm_vld),
  .brk(brk), .code_o(code_o), .valid_o(valid_o)
);

// File: tb/ps2_key_rx_test.sv
module ps2_key_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kclk = 1'b1;
  logic       kdat = 1'b1;
  logic [7:0] code;
  logic       valid;

  int unsigned nvec = 0;
  int unsigned nerr = 0;
  logic [7:0]  exp_q[$];
  logic [7:0]  last_code = 8'h00;
  bit          brk_m = 1'b0;
  bit          prev_valid = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ps2_key_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .ps2_clk_i(kclk), .ps2_data_i(kdat),
    .code_o(code), .valid_o(valid)
  );

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid && prev_valid) begin
        nvec++; nerr++;
        $display("FAIL R4: strobe longer than one cycle, got 1 expected 0");
      end
      if (valid) begin
        nvec++;
        if (exp_q.size() == 0) begin
          nerr++;
          $display("FAIL R7/R8/R6: unexpected strobe code %02h, expected none", code);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (code !== e) begin
            nerr++;
            $display("FAIL R3: code %02h expected %02h", code, e);
          end
          last_code = e;
        end
      end
      prev_valid = valid;
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic low_glitch(int n);
    #2 kclk = 1'b0;
    wait_clk(n);
    #2 kclk = 1'b1;
  endtask

  // one frame; glitch: short low pulse in high phase of each bit
  task automatic send_frame(logic [7:0] b, bit bad_par, bit glitch);
    logic [10:0] bits;
    bits = {1'b1, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      #2 kdat = bits[i];
      wait_clk(6);
      if (glitch) low_glitch(4);
      wait_clk(6);
      #2 kclk = 1'b0;
      wait_clk(20);
      #2 kclk = 1'b1;
      wait_clk(8);
    end
    #2 kdat = 1'b1;
  endtask

  // driver: reference model of requirements pushes expectations
  task automatic key(logic [7:0] b, bit bad_par, bit glitch, string tag);
    if (!bad_par) begin
      if (b == 8'hF0) brk_m = 1'b1;
      else if (b != 8'hE0) begin
        if (brk_m) brk_m = 1'b0;
        else exp_q.push_back(b);
      end
    end
    send_frame(b, bad_par, glitch);
    wait_clk(40);
    @(negedge clk);
    nvec++;
    if (exp_q.size() != 0) begin  // R9: no lag
      nerr++;
      $display("FAIL R9 (%s): %0d strobes missing, expected 0", tag, exp_q.size());
      exp_q.delete();
    end
    nvec++;
    if (code !== last_code) begin  // R5
      nerr++;
      $display("FAIL R5 (%s): code_o %02h expected %02h", tag, code, last_code);
    end
  endtask

  initial begin
    wait_clk(3);
    @(negedge clk);
    nvec++;
    if (valid !== 1'b0 || code !== 8'h00) begin
      nerr++;
      $display("FAIL R1: valid %b code %02h expected 0 00", valid, code);
    end
    rst_n = 1'b1;
    wait_clk(20);
    @(negedge clk);
    nvec++;
    if (valid !== 1'b0 || code !== 8'h00) begin
      nerr++;
      $display("FAIL R1: after release valid %b code %02h expected 0 00", valid, code);
    end

    key(8'h1C, 0, 0, "R3 basic");
    wait_clk(10); #2 kdat = 1'b0; low_glitch(5); wait_clk(10); #2 kdat = 1'b1;
    key(8'h32, 0, 0, "R2 idle glitch");
    key(8'h4D, 0, 1, "R2 bit glitch");
    key(8'hF0, 0, 0, "R7 prefix");
    key(8'h1C, 0, 0, "R7 suppressed");
    key(8'h1C, 0, 0, "R7 repeat");
    key(8'hE0, 0, 0, "R8 ext");
    key(8'h75, 0, 0, "R8 ext key");
    key(8'hE0, 0, 0, "R8 ext");
    key(8'hF0, 0, 0, "R8 ext release");
    key(8'h75, 0, 0, "R8 ext released");
    key(8'h2B, 1, 0, "R6 bad parity");
    key(8'h2B, 0, 0, "R6 good parity");
    key(8'hF0, 1, 0, "R6 bad prefix");
    key(8'h00, 0, 0, "R3 zero byte");
    key(8'hFF, 0, 0, "R3 ones byte");
    key(8'hA5, 0, 0, "R4 pattern");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(200000 * 10);
    done = 1'b1;
    nvec++; nerr++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule